// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one processor-side transfer at a time on a 16-bit bus where address and data share the same lines, with a 20-bit address. The core hands it a request: read, write or interrupt acknowledge, memory or I/O, byte or word, plus the address, write data, segment code and interrupt-enable flag. The sequencer then walks the bus states T1, T2, T3, any number of wait states Tw, and T4. It produces the address-latch strobe, the read, write and acknowledge strobes, the memory/IO and direction lines, the high-byte enable and the output enable for the shared lines. It also returns the captured read data with a one-cycle done pulse.

A slow target holds READY low to stretch the transfer. A new request is taken while the sequencer is idle or in T4, so transfers can run back to back with no idle clock between them. Splitting an odd-address word into two byte transfers is left to the requester.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the sequencer is idle. The latch strobe is low, the read, write and acknowledge strobes are high, the shared lines are not driven, done is low and req_accept is high.
- R2: ale is high for exactly one clock, in T1, the clock after a request is accepted. It is never high two clocks in a row.
- R3: In T1 ad_out carries address bits 15..0. ad_oe is high, except in an acknowledge transfer, where it stays low. a_hi carries address bits 19..16 for a memory transfer and 0000 for I/O and acknowledge transfers.
- R4: From T2 through T4, a_hi carries status {0, ie, seg}. Here ie is the flag captured with the request, and seg is the 2-bit segment code (00 alternate, 01 stack, 10 code or none, 11 data). The status is stable across the data phase.
- R5: From T1 to T4, bhe_n is 0 for a word or for a byte at an odd address, and 1 for a byte at an even address. Together with ad_out[0] in T1 this gives 00 for a word, 01 for an upper byte and 10 for a lower byte. An acknowledge transfer drives bhe_n low.
- R6: For a read (req_kind 00 or 11), rd_n is low in T2, T3 and every Tw and high otherwise. Whenever rd_n is low, ad_oe is low.
- R7: For a write (req_kind 01), wr_n is low in T2, T3 and every Tw. From T2 through T4, ad_oe is high and ad_out equals the write data.
- R8: For an interrupt acknowledge (req_kind 10), inta_n is low in T2, T3 and every Tw. ad_oe stays low for the whole transfer. At most one of rd_n, wr_n and inta_n is low at any time.
- R9: READY is sampled at the clock edge ending T3 and at the edge ending each Tw. Each low sample adds one Tw, and the first high sample moves to T4.
- R10: For read and acknowledge transfers, ad_in is captured at the edge that ends the last T3 or Tw. The captured value appears on rdata from T4 and is held until the next capture.
- R11: done is high for exactly one clock, in T4.
- R12: m_io (1 = memory) and dt_r (1 = transmit, i.e. write) show the new request's values in the clock where it is accepted and hold them until that transfer's T4. An acknowledge gives m_io = 0 and dt_r = 0.
- R13: req_accept is high only when idle or in T4. A request presented while req_accept is low is ignored and changes neither m_io nor the transfer in progress. A request accepted in T4 begins T1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 read, 01 write, 10 interrupt acknowledge, 11 read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = word transfer, 0 = byte |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_seg | input | 2 | Segment code shown as status |
| req_ie | input | 1 | Interrupt-enable flag shown as status |
| ready | input | 1 | Target ready, active high |
| ad_in | input | 16 | Data read from the shared lines |
| req_accept | output | 1 | Sequencer can take a request this clock |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| a_hi | output | 4 | Upper address in T1, status afterwards |
| bhe_n | output | 1 | High-byte enable, active low |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| m_io | output | 1 | Memory (1) or I/O (0) |
| dt_r | output | 1 | Transmit (1) or receive (0) |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-clock pulse in T4 |

## Verification
The hardest situation to reach is a new request landing in T4 of the previous transfer. This case is the only place where m_io and dt_r switch to the next transfer's values before the old one ends, and where T1 follows T4 directly. The bench reaches it by starting the next transfer task at the very sampling point where the previous task finished its T4 checks. It then checks the accept, the early switch of m_io and dt_r, and the latch strobe on the following clock. A stray request raised in the middle of every transfer shows at the ports that busy-time requests are ignored. Stretches of one, two and five wait states show that READY sampling is done edge by edge.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_INTA  = 2'b10;

  // active-low high-byte enable from transfer size and address bit 0
  function automatic logic bhe_n_of(input logic word, input logic a0);
    return !(word || a0);
  endfunction

  // status shown on the upper lines after T1: {0, ie, seg}
  function automatic logic [3:0] status_of(input logic ie, input logic [1:0] seg);
    return {1'b0, ie, seg};
  endfunction

  function automatic logic in_strobe(input tstate_e s);
    return (s == TS_T2) || (s == TS_T3) || (s == TS_TW);
  endfunction

  function automatic logic in_sample(input tstate_e s);
    return (s == TS_T3) || (s == TS_TW);
  endfunction
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    ready,
  output tstate_e state
);
  tstate_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      TS_IDLE: nxt = start ? TS_T1 : TS_IDLE;
      TS_T1:   nxt = TS_T2;
      TS_T2:   nxt = TS_T3;
      TS_T3,
      TS_TW:   nxt = ready ? TS_T4 : TS_TW;
      TS_T4:   nxt = start ? TS_T1 : TS_IDLE;
      default: nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= TS_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/mbs_req_hold.sv
module mbs_req_hold #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        kind,
  input  logic              mem,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        seg,
  input  logic              ie,
  output logic [1:0]        h_kind,
  output logic              h_mem,
  output logic              h_word,
  output logic [ADDR_W-1:0] h_addr,
  output logic [DATA_W-1:0] h_wdata,
  output logic [1:0]        h_seg,
  output logic              h_ie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_kind  <= '0;
      h_mem   <= 1'b0;
      h_word  <= 1'b0;
      h_addr  <= '0;
      h_wdata <= '0;
      h_seg   <= '0;
      h_ie    <= 1'b0;
    end else if (load) begin
      h_kind  <= kind;
      h_mem   <= mem;
      h_word  <= word;
      h_addr  <= addr;
      h_wdata <= wdata;
      h_seg   <= seg;
      h_ie    <= ie;
    end
  end
endmodule

// File: rtl/mbs_bus_drive.sv
module mbs_bus_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  tstate_e           state,
  input  logic [1:0]        h_kind,
  input  logic              h_mem,
  input  logic              h_word,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [1:0]        h_seg,
  input  logic              h_ie,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n
);
  logic is_wr, is_ack, is_rd, strobe;

  assign is_wr  = (h_kind == KIND_WRITE);
  assign is_ack = (h_kind == KIND_INTA);
  assign is_rd  = !is_wr && !is_ack;
  assign strobe = in_strobe(state);

  assign rd_n   = !(strobe && is_rd);
  assign wr_n   = !(strobe && is_wr);
  assign inta_n = !(strobe && is_ack);
  assign ale    = (state == TS_T1);

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    a_hi   = '0;
    bhe_n  = 1'b1;
    if (state == TS_T1) begin
      ad_out = h_addr[DATA_W-1:0];
      ad_oe  = !is_ack;
      a_hi   = (h_mem && !is_ack) ? h_addr[ADDR_W-1:DATA_W] : '0;
      bhe_n  = is_ack ? 1'b0 : bhe_n_of(h_word, h_addr[0]);
    end else if (state != TS_IDLE) begin
      a_hi   = HI_W'(status_of(h_ie, h_seg));
      bhe_n  = is_ack ? 1'b0 : bhe_n_of(h_word, h_addr[0]);
      ad_oe  = is_wr;
      ad_out = is_wr ? h_wdata : '0;
    end
  end
endmodule

// File: rtl/mbs_rdata.sv
module mbs_rdata #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= ad_in;
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_mem,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_seg,
  input  logic              req_ie,
  input  logic              ready,
  input  logic [DATA_W-1:0] ad_in,
  output logic              req_accept,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              m_io,
  output logic              dt_r,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  tstate_e           state;
  logic              start;
  logic [1:0]        h_kind;
  logic              h_mem, h_word, h_ie;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic [1:0]        h_seg;

  // named internal events for the checker
  logic st_idle, st_sample, st_data, rd_capture;

  assign st_idle    = (state == TS_IDLE);
  assign st_sample  = in_sample(state);
  assign st_data    = in_strobe(state);
  assign req_accept = st_idle || (state == TS_T4);
  assign start      = req_valid && req_accept;
  assign rd_capture = st_sample && ready && (h_kind != KIND_WRITE);
  assign done       = (state == TS_T4);

  assign m_io = start ? (req_mem && (req_kind != KIND_INTA))
                      : (h_mem && (h_kind != KIND_INTA));
  assign dt_r = start ? (req_kind == KIND_WRITE) : (h_kind == KIND_WRITE);

  mbs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .state(state)
  );

  mbs_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(start),
    .kind(req_kind), .mem(req_mem), .word(req_word), .addr(req_addr),
    .wdata(req_wdata), .seg(req_seg), .ie(req_ie),
    .h_kind(h_kind), .h_mem(h_mem), .h_word(h_word), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_seg(h_seg), .h_ie(h_ie)
  );

  mbs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .state(state), .h_kind(h_kind), .h_mem(h_mem), .h_word(h_word),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_seg(h_seg), .h_ie(h_ie),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .bhe_n(bhe_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n)
  );

  mbs_rdata #(.DATA_W(DATA_W)) u_rdata (
    .clk(clk), .rst_n(rst_n), .capture(rd_capture), .ad_in(ad_in), .rdata(rdata)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int HI_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_accept,
  input logic            ready,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            inta_n,
  input logic            ad_oe,
  input logic            done,
  input logic [HI_W-1:0] a_hi,
  input logic            st_idle,
  input logic            st_sample,
  input logic            st_data
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (rd_n && wr_n && inta_n && !ale && !done));

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_data && $past(st_data)) |-> $stable(a_hi));

  p_rd_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n, !inta_n}) <= 1);

  p_ack_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> !ad_oe);

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sample && !ready) |=> st_sample);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_t1_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_accept) |=> ale);
endmodule

bind mux_bus_seq mbs_checker #(.HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_accept(req_accept),
  .ready(ready), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
  .ad_oe(ad_oe), .done(done), .a_hi(a_hi), .st_idle(st_idle),
  .st_sample(st_sample), .st_data(st_data)
);

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_mem = 1'b0;
  logic        req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_seg = '0;
  logic        req_ie = 1'b0;
  logic        ready = 1'b1;
  logic [15:0] ad_in = '0;
  logic        req_accept, ad_oe, bhe_n, ale, rd_n, wr_n, inta_n, m_io, dt_r, done;
  logic [15:0] ad_out, rdata;
  logic [3:0]  a_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mux_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_mem(req_mem), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie),
    .ready(ready), .ad_in(ad_in), .req_accept(req_accept), .ad_out(ad_out),
    .ad_oe(ad_oe), .a_hi(a_hi), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .inta_n(inta_n), .m_io(m_io), .dt_r(dt_r), .rdata(rdata),
    .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // strobes in the data phase: returns {rd_n, wr_n, inta_n}
  function automatic logic [2:0] exp_strobes(input logic [1:0] kind);
    if (kind == 2'b01)      return 3'b101;
    else if (kind == 2'b10) return 3'b110;
    else                    return 3'b011;
  endfunction

  // Must be entered at a falling edge where req_accept is expected high.
  // Returns at the falling edge inside T4, after checking it.
  task automatic run_xfer(input logic [1:0] kind, input logic mem, input logic word,
                          input logic [19:0] addr, input logic [15:0] wdata,
                          input logic [1:0] seg, input logic ie,
                          input int nwait, input logic [15:0] rval);
    logic ack, wr;
    logic exp_mio, exp_bhe;
    logic [3:0] exp_hi1;
    ack = (kind == 2'b10);
    wr  = (kind == 2'b01);
    exp_mio = mem && !ack;
    exp_bhe = ack ? 1'b0 : !(word || addr[0]);
    exp_hi1 = (mem && !ack) ? addr[19:16] : 4'h0;

    // accept clock
    req_valid = 1'b1; req_kind = kind; req_mem = mem; req_word = word;
    req_addr = addr; req_wdata = wdata; req_seg = seg; req_ie = ie;
    #1;
    chk("R13 accept when idle or T4", req_accept, 1);
    chk("R12 m_io early", m_io, exp_mio);
    chk("R12 dt_r early", dt_r, wr);

    // T1
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R2 ale in T1", ale, 1);
    chk("R3 ad_out address", ad_out, addr[15:0]);
    chk("R3 ad_oe in T1", ad_oe, !ack);
    chk("R3 upper lines in T1", a_hi, exp_hi1);
    chk("R5 bhe_n in T1", bhe_n, exp_bhe);
    chk("R6 strobes idle in T1", {rd_n, wr_n, inta_n}, 3'b111);

    // T2
    @(negedge clk); #1;
    chk("R2 ale low in T2", ale, 0);
    chk("R4 status in T2", a_hi, {1'b0, ie, seg});
    chk("R5 bhe_n held in T2", bhe_n, exp_bhe);
    chk("R6 R7 R8 strobes in T2", {rd_n, wr_n, inta_n}, exp_strobes(kind));
    chk("R7 R8 ad_oe in T2", ad_oe, wr);
    if (wr) chk("R7 write data in T2", ad_out, wdata);
    // stray request while busy must be ignored
    req_valid = 1'b1; req_mem = !mem; req_kind = 2'b01;
    #1;
    chk("R13 no accept while busy", req_accept, 0);
    chk("R13 m_io unchanged by stray request", m_io, exp_mio);
    chk("R13 dt_r unchanged by stray request", dt_r, wr);
    req_valid = 1'b0; req_mem = mem; req_kind = kind;

    // T3
    @(negedge clk);
    ready = (nwait == 0);
    ad_in = rval;
    #1;
    chk("R6 R7 R8 strobes in T3", {rd_n, wr_n, inta_n}, exp_strobes(kind));
    chk("R11 no done in T3", done, 0);
    chk("R12 m_io held in T3", m_io, exp_mio);

    // Tw
    for (int w = 0; w < nwait; w++) begin
      @(negedge clk);
      ready = (w == nwait - 1);
      #1;
      chk("R9 wait state keeps strobe", {rd_n, wr_n, inta_n}, exp_strobes(kind));
      chk("R9 no done in wait state", done, 0);
      chk("R4 status held in wait", a_hi, {1'b0, ie, seg});
    end

    // T4
    @(negedge clk);
    ready = 1'b1;
    ad_in = 16'hDEAD;
    #1;
    chk("R11 done in T4", done, 1);
    chk("R6 R7 R8 strobes off in T4", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R7 ad_oe in T4", ad_oe, wr);
    chk("R12 m_io held in T4", m_io, exp_mio);
    chk("R12 dt_r held in T4", dt_r, wr);
    if (!wr) chk("R10 read data captured", rdata, rval);
  endtask

  task automatic go_idle();
    @(negedge clk); #1;
    chk("R11 done drops after T4", done, 0);
    chk("R1 idle strobes", {ale, rd_n, wr_n, inta_n}, 4'b0111);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset ale", ale, 0);
    chk("R1 reset strobes", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R1 reset ad_oe", ad_oe, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset accept", req_accept, 1);
  endtask

  task automatic t_word_read();
    run_xfer(2'b00, 1'b1, 1'b1, 20'hA1234, 16'h0, 2'b11, 1'b1, 0, 16'hBEEF);
    go_idle();
  endtask

  task automatic t_byte_write_odd();
    run_xfer(2'b01, 1'b1, 1'b0, 20'h35557, 16'h5AA5, 2'b01, 1'b0, 2, 16'h0);
    go_idle();
    chk("R10 rdata held across write", rdata, 16'hBEEF);
  endtask

  task automatic t_io_read_even();
    run_xfer(2'b00, 1'b0, 1'b0, 20'hF0046, 16'h0, 2'b10, 1'b1, 1, 16'h00C3);
    go_idle();
  endtask

  task automatic t_inta();
    run_xfer(2'b10, 1'b1, 1'b0, 20'h00000, 16'h0, 2'b00, 1'b0, 0, 16'h0021);
    go_idle();
  endtask

  task automatic t_back_to_back();
    run_xfer(2'b01, 1'b1, 1'b1, 20'h8C000, 16'h1357, 2'b11, 1'b1, 0, 16'h0);
    // next request presented in T4
    run_xfer(2'b00, 1'b0, 1'b1, 20'h00310, 16'h0, 2'b10, 1'b0, 1, 16'h2468);
    run_xfer(2'b11, 1'b1, 1'b0, 20'h7FFFF, 16'h0, 2'b00, 1'b1, 0, 16'h9ABC);
    go_idle();
  endtask

  task automatic t_long_wait();
    run_xfer(2'b00, 1'b1, 1'b1, 20'h4F00E, 16'h0, 2'b01, 1'b0, 5, 16'h7E81);
    go_idle();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_reset();
    t_word_read();
    t_byte_write_odd();
    t_io_read_even();
    t_inta();
    t_back_to_back();
    t_long_wait();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule